// File: doc/BRIEF.md
# Fast PWM Timer Compare Unit

This block is an 8-bit single-slope PWM generator. A free-running prescaler produces a count enable at one of five divisors. On each enable an up-counter steps from 0x00 to 0xFF and then returns to 0x00, so every PWM period lasts 256 count ticks. A single compare channel watches the counter and drives one waveform output. The output mode selects one of four behaviours: off, toggle on match, non-inverted PWM or inverted PWM.

Software writes the compare value into a holding register. The value becomes active only when the counter passes its top, so a period that is already running never takes a duty change partway through. Two sticky flags report the counter wrap and the compare match. Writing a one to the matching clear strobe clears a flag. Two compare values have fixed meanings: zero gives a pulse one tick wide, and 0xFF gives a constant level.

Top module: `fpwm_timer`

## Requirements
- R1: While count ticks occur, the counter steps 0,1,...,255 and then 0 again, so one PWM period is 256 ticks.
- R2: The clock-select field sets the tick divisor N: 1 gives N=1, 2 gives N=8, 3 gives N=64, 4 gives N=256 and 5 gives N=1024. The values 0, 6 and 7 stop the counter, which freezes both flags and the output. With N>1, the counter, the flags and the output change only on tick clocks.
- R3: The overflow flag is set by the tick on which the counter equals 255 and reads 1 from the next clock. A one on the overflow clear input clears it, but a set on the same clock wins over the clear.
- R4: A write to the compare port loads only a holding register. The active compare value copies the holding register on the tick where the counter wraps from 255 to 0, so the current period keeps its old duty.
- R5: Mode 2 (non-inverted) sets the output on the wrap tick and clears it on a match tick, so the output is high for (C+1)·N clocks per period when C<255.
- R6: Mode 3 (inverted) clears the output on the wrap tick and sets it on a match tick, so the output is high for (255−C)·N clocks per period.
- R7: Extreme compare values: C=0 gives a high pulse one tick long in mode 2. C=255 gives a constant high in mode 2 and a constant low in mode 3, because the wrap action wins over a match on the same tick.
- R8: Mode 1 inverts the output on every match tick. The result is a 50% square wave with a period of 512 ticks.
- R9: Mode 0 holds the output at 0 from the next clock, and the match flag is still set on every match.
- R10: The match flag is set by the tick on which the counter equals the active compare value and reads 1 from the next clock. A one on the match clear input clears it, and a set wins over a clear.
- R11: Synchronous reset clears the prescaler, the counter, the holding and active compare registers, both flags and the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Tick divisor select (0, 6, 7 stop the counter) |
| out_mode | input | 2 | Output mode: 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| cmp_wr | input | 1 | Compare holding register write strobe |
| cmp_wdata | input | 8 | Compare value to write |
| ovf_clr | input | 1 | Write-one clear for the overflow flag |
| match_clr | input | 1 | Write-one clear for the match flag |
| wave_out | output | 1 | PWM waveform output |
| ovf_flag | output | 1 | Sticky counter-wrap flag |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
A wrong counter value or a wrong prescaler phase moves both the wrap and the match. Within one period the overflow flag then rises at the wrong clock and the high time of the waveform changes. The bench therefore aligns to the rising overflow flag and counts high samples over a whole period. A bad active compare value shows up as a wrong duty in the first period after its load. A compare register that loads too early changes the duty of the period in which the write happens. A wrong flag set or clear priority shows up at the clock after a match or a wrap.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } out_mode_e;

  // Largest divisor exponent (N = 1024)
  localparam int unsigned PRE_LOG2_MAX = 10;

  // log2 of the tick divisor for a clock-select code
  function automatic int unsigned pre_log2(input logic [2:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return 0;
    endcase
  endfunction

  // A select code that actually produces ticks
  function automatic logic sel_runs(input logic [2:0] sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

  // Next output level given the mode and the events of this clock
  function automatic logic wave_next(input out_mode_e mode, input logic cur,
                                     input logic wrap, input logic match);
    case (mode)
      OM_TOGGLE: return match ? ~cur : cur;
      OM_NONINV: return wrap ? 1'b1 : (match ? 1'b0 : cur);
      OM_INV:    return wrap ? 1'b0 : (match ? 1'b1 : cur);
      default:   return 1'b0;
    endcase
  endfunction

  // Sticky flag update: set beats clear
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
  parameter int unsigned PRE_W = fpwm_pkg::PRE_LOG2_MAX
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clk_sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    mask = PRE_W'((32'd1 << fpwm_pkg::pre_log2(clk_sel)) - 32'd1);
    tick = fpwm_pkg::sel_runs(clk_sel) && ((pre_q & mask) == mask);
  end
endmodule

// File: rtl/fpwm_count.sv
module fpwm_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ocr_buf_q,
  output logic [CNT_W-1:0] ocr_act_q,
  output logic             wrap_evt,
  output logic             match_evt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  assign wrap_evt  = tick && (cnt_q == CNT_TOP);
  assign match_evt = tick && (cnt_q == ocr_act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      ocr_buf_q <= '0;
      ocr_act_q <= '0;
    end else begin
      if (cmp_wr)   ocr_buf_q <= cmp_wdata;
      if (wrap_evt) ocr_act_q <= ocr_buf_q;
      if (tick)     cnt_q     <= wrap_evt ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fpwm_wavegen.sv
module fpwm_wavegen (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] out_mode,
  input  logic       wrap_evt,
  input  logic       match_evt,
  input  logic       ovf_clr,
  input  logic       match_clr,
  output logic       wave_q,
  output logic       ovf_q,
  output logic       match_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q  <= 1'b0;
      ovf_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      wave_q  <= fpwm_pkg::wave_next(fpwm_pkg::out_mode_e'(out_mode), wave_q,
                                     wrap_evt, match_evt);
      ovf_q   <= fpwm_pkg::flag_next(ovf_q, wrap_evt, ovf_clr);
      match_q <= fpwm_pkg::flag_next(match_q, match_evt, match_clr);
    end
  end
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = fpwm_pkg::PRE_LOG2_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       clk_sel,
  input  logic [1:0]       out_mode,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             ovf_clr,
  input  logic             match_clr,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             match_flag
);
  // Named internal events, observed by the bound checker
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ocr_buf_q;
  logic [CNT_W-1:0] ocr_act_q;
  logic             wrap_evt;
  logic             match_evt;

  fpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clk_sel (clk_sel),
    .tick    (tick)
  );

  fpwm_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (cmp_wdata),
    .cnt_q     (cnt_q),
    .ocr_buf_q (ocr_buf_q),
    .ocr_act_q (ocr_act_q),
    .wrap_evt  (wrap_evt),
    .match_evt (match_evt)
  );

  fpwm_wavegen u_wave (
    .clk       (clk),
    .rst       (rst),
    .out_mode  (out_mode),
    .wrap_evt  (wrap_evt),
    .match_evt (match_evt),
    .ovf_clr   (ovf_clr),
    .match_clr (match_clr),
    .wave_q    (wave_out),
    .ovf_q     (ovf_flag),
    .match_q   (match_flag)
  );
endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       clk_sel,
  input logic [1:0]       out_mode,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] ocr_buf_q,
  input logic [CNT_W-1:0] ocr_act_q,
  input logic             wrap_evt,
  input logic             match_evt,
  input logic             wave_out,
  input logic             ovf_flag,
  input logic             match_flag
);
  logic [2:0]  prev_sel;
  int unsigned gap;

  always_ff @(posedge clk) begin
    prev_sel <= clk_sel;
    if (rst || tick || (clk_sel != prev_sel)) gap <= 0;
    else                                      gap <= gap + 1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (cnt_q == '0)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap_evt) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q)); // R2
  AST_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !fpwm_pkg::sel_runs(clk_sel) |-> !tick); // R2
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (fpwm_pkg::sel_runs(clk_sel) && clk_sel == prev_sel)
      |-> (gap < (32'd1 << fpwm_pkg::pre_log2(clk_sel)))); // R2
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> ovf_flag); // R3
  AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (ocr_act_q == $past(ocr_buf_q))); // R4
  AST_ACT_HELD: assert property (@(posedge clk) disable iff (rst)
    !wrap_evt |=> $stable(ocr_act_q)); // R4
  AST_NONINV_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && out_mode == 2'd2) |=> wave_out); // R5
  AST_INV_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && out_mode == 2'd3) |=> !wave_out); // R6
  AST_MODE_OFF: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 2'd0) |=> !wave_out); // R9
  AST_MATCH_SET: assert property (@(posedge clk) disable iff (rst)
    match_evt |=> match_flag); // R10
endmodule

bind fpwm_timer fpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_sel    (clk_sel),
  .out_mode   (out_mode),
  .tick       (tick),
  .cnt_q      (cnt_q),
  .ocr_buf_q  (ocr_buf_q),
  .ocr_act_q  (ocr_act_q),
  .wrap_evt   (wrap_evt),
  .match_evt  (match_evt),
  .wave_out   (wave_out),
  .ovf_flag   (ovf_flag),
  .match_flag (match_flag)
);

// File: tb/fpwm_timer_bench.sv
module fpwm_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clk_sel = 3'd1;
  logic [1:0] out_mode = 2'd2;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = 8'd0;
  logic       ovf_clr = 1'b0;
  logic       match_clr = 1'b0;
  logic       wave_out, ovf_flag, match_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fpwm_timer u_fpwm_timer (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .out_mode(out_mode),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ovf_clr(ovf_clr),
    .match_clr(match_clr), .wave_out(wave_out), .ovf_flag(ovf_flag),
    .match_flag(match_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cmp(input int v);
    cmp_wr = 1'b1; cmp_wdata = 8'(v);
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  // Leaves the bench at the first sample after a wrap (counter = 0)
  task automatic sync_wrap();
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    while (!ovf_flag) @(negedge clk);
  endtask

  task automatic measure(input int n, output int hi, output int edges);
    logic prev;
    hi = 0; edges = 0; prev = wave_out;
    for (int i = 0; i < n; i++) begin
      if (wave_out) hi++;
      if (wave_out != prev) edges++;
      prev = wave_out;
      @(negedge clk);
    end
  endtask

  function automatic int expect_high(input int mode, input int c, input int n);
    int base;
    base = (c == 255) ? 256 : c + 1;
    if (mode == 2) return base * n;
    if (mode == 3) return (256 - base) * n;
    return 0;
  endfunction

  task automatic duty_case(input int sel, input int n, input int mode, input int c,
                           input string req);
    int hi, ed;
    clk_sel = 3'(sel); out_mode = 2'(mode);
    write_cmp(c);
    sync_wrap();
    sync_wrap();
    measure(256 * n, hi, ed);
    chk(hi == expect_high(mode, c, n), req, hi, expect_high(mode, c, n));
  endtask

  initial begin
    #(190000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi, ed;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(wave_out == 1'b0, "R11 wave", int'(wave_out), 0);
    chk(ovf_flag == 1'b0, "R11 ovf", int'(ovf_flag), 0);
    chk(match_flag == 1'b0, "R11 match", int'(match_flag), 0);
    rst = 1'b0;
    // R1/R3: first wrap after exactly 256 ticks from reset
    repeat (255) @(negedge clk);
    chk(ovf_flag == 1'b0, "R3 before first wrap", int'(ovf_flag), 0);
    @(negedge clk);
    chk(ovf_flag == 1'b1, "R1 R3 first wrap at 256", int'(ovf_flag), 1);

    // R5/R6/R7: duty sweep at N=1
    for (int c = 0; c < 256; c += 8) duty_case(1, 1, 2, c, "R5 noninv duty");
    for (int c = 0; c < 256; c += 8) duty_case(1, 1, 3, c, "R6 inv duty");
    duty_case(1, 1, 2, 0, "R7 spike");
    duty_case(1, 1, 2, 255, "R7 const high");
    duty_case(1, 1, 3, 255, "R7 const low");
    duty_case(1, 1, 2, 254, "R5 noninv 254");
    duty_case(1, 1, 3, 1, "R6 inv 1");

    // R2: prescaled operation
    duty_case(2, 8, 2, 63, "R2 N=8 duty");
    duty_case(2, 8, 3, 200, "R2 N=8 inv duty");
    duty_case(3, 64, 2, 100, "R2 N=64 duty");

    // R8: toggle mode
    clk_sel = 3'd1; out_mode = 2'd1;
    write_cmp(37);
    sync_wrap(); sync_wrap(); sync_wrap();
    measure(512, hi, ed);
    chk(hi == 256, "R8 toggle high time", hi, 256);
    chk(ed == 2, "R8 toggle edges", ed, 2);

    // R4: double buffering
    out_mode = 2'd2;
    write_cmp(200);
    sync_wrap(); sync_wrap();
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      cmp_wr = (i == 10); cmp_wdata = 8'd50;
      if (wave_out) hi++;
      @(negedge clk);
    end
    cmp_wr = 1'b0;
    chk(hi == 201, "R4 old value kept this period", hi, 201);
    measure(256, hi, ed);
    chk(hi == 51, "R4 new value next period", hi, 51);

    // R10: match flag timing and clearing
    write_cmp(100);
    sync_wrap(); sync_wrap();
    match_clr = 1'b1;
    @(negedge clk);
    match_clr = 1'b0;
    chk(match_flag == 1'b0, "R10 cleared", int'(match_flag), 0);
    repeat (99) @(negedge clk);
    chk(match_flag == 1'b0, "R10 before match", int'(match_flag), 0);
    chk(wave_out == 1'b1, "R5 high before match", int'(wave_out), 1);
    @(negedge clk);
    chk(match_flag == 1'b1, "R10 one clock after match", int'(match_flag), 1);
    chk(wave_out == 1'b0, "R5 low after match", int'(wave_out), 0);
    // R3: write-one clear of overflow away from a wrap
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk(ovf_flag == 1'b0, "R3 cleared", int'(ovf_flag), 0);

    // R9: mode off holds output low, match flag still sets
    out_mode = 2'd0;
    write_cmp(80);
    sync_wrap(); sync_wrap();
    match_clr = 1'b1;
    @(negedge clk);
    match_clr = 1'b0;
    measure(256, hi, ed);
    chk(hi == 0, "R9 output held low", hi, 0);
    chk(match_flag == 1'b1, "R9 match flag still sets", int'(match_flag), 1);

    // R2: stopped select freezes flags and output
    out_mode = 2'd2;
    write_cmp(128);
    sync_wrap(); sync_wrap();
    clk_sel = 3'd0;
    ovf_clr = 1'b1; match_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0; match_clr = 1'b0;
    measure(600, hi, ed);
    chk(ed == 0, "R2 stopped output frozen", ed, 0);
    chk(ovf_flag == 1'b0, "R2 stopped no wrap", int'(ovf_flag), 0);
    chk(match_flag == 1'b0, "R2 stopped no match", int'(match_flag), 0);
    clk_sel = 3'd7;
    measure(300, hi, ed);
    chk(ovf_flag == 1'b0 && match_flag == 1'b0, "R2 select 7 stopped",
        int'(ovf_flag) + int'(match_flag), 0);

    // R11: reset in mid-run
    clk_sel = 3'd1;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(wave_out == 1'b0 && ovf_flag == 1'b0 && match_flag == 1'b0,
        "R11 mid-run reset", int'(wave_out) + int'(ovf_flag) + int'(match_flag), 0);
    repeat (256) @(negedge clk);
    chk(ovf_flag == 1'b1, "R11 counter restarted", int'(ovf_flag), 1);
    chk(wave_out == 1'b1, "R11 compare buffer cleared (spike)", int'(wave_out), 1);
    @(negedge clk);
    chk(wave_out == 1'b0, "R11 spike ends", int'(wave_out), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule